// File: doc/BRIEF.md
# Transmit Byte Queue with Low-Water Trigger

This block is a 32-deep, 8-bit first-in first-out queue on a transmit path. A host-side producer pushes one byte per accepted write beat. A downstream consumer, such as a modulator or line encoder, pops bytes from the head. A programmable 5-bit low-water level is compared against the number of stored bytes. When the fill is at or below that level, a trigger bit in a status byte goes high. The trigger can also drive a level-sensitive interrupt request, so the producer knows to refill before the consumer runs dry.

Both data sides use valid/ready handshakes. A write beat transfers when `wr_valid` and `wr_ready` are both high at a rising clock edge. While the queue is full, `wr_ready` is low, and a beat offered then is discarded rather than held. The producer need not keep `wr_valid` asserted, and the event is recorded as a sticky overflow. A read beat transfers when `rd_valid` and `rd_ready` are both high. If the consumer asserts `rd_ready` while the queue is empty, it sees a zero byte and a sticky underflow is recorded. The threshold register, interrupt enable and sticky-clear are plain control pins.

Top module: `txq_lowwater_top`

## Requirements
- R1: A write beat is accepted at a rising edge when `wr_valid` and `wr_ready` are both high. `wr_ready` is high exactly while fewer than 32 bytes are stored. Bytes leave in the order they were accepted.
- R2: `fill` (0 to 32) equals the number of stored bytes and changes on the edge that follows a transfer. An accepted write and an accepted read in the same cycle leave it unchanged.
- R3: After reset the queue is empty, `fill` is 0, `thr_q` is 0x00, both sticky bits are 0, and `status` reads 0x80.
- R4: When `thr_we` is high at an edge, bits 4..0 of `thr_wdata` become the level. Bits 7..5 are ignored. `thr_q` reads the level back with bits 7..5 zero.
- R5: `status[7]` is 1 exactly when `fill` is less than or equal to the level in `thr_q[4:0]`.
- R6: `rd_valid` is high while the queue is not empty, and `rd_data` then shows the oldest byte. A read beat with `rd_valid` and `rd_ready` both high removes that byte.
- R7: A beat with `wr_valid` high while the queue is full is discarded and leaves the contents unchanged. From the next edge, `status[1]` (overflow) is 1 and stays 1.
- R8: While the queue is empty, `rd_data` is 0x00. If `rd_ready` is high then, `status[0]` (underflow) is 1 from the next edge and stays 1.
- R9: `irq` is high exactly when `status[7]` is 1 and `irq_en` is 1.
- R10: `sts_clr` high at an edge clears both sticky bits, unless an overflow or underflow event occurs in that same cycle, in which case that bit is set. `status[6:2]` always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer offers a byte |
| wr_ready | output | 1 | Queue has room |
| wr_data | input | 8 | Byte offered by producer |
| rd_valid | output | 1 | Queue holds at least one byte |
| rd_ready | input | 1 | Consumer takes the head byte |
| rd_data | output | 8 | Head byte, zero when empty |
| thr_we | input | 1 | Load the low-water level |
| thr_wdata | input | 8 | Level value, bits 7..5 ignored |
| thr_q | output | 8 | Stored level, bits 7..5 zero |
| irq_en | input | 1 | Interrupt enable |
| sts_clr | input | 1 | Clear overflow and underflow bits |
| status | output | 8 | Bit 7 trigger, bit 1 overflow, bit 0 underflow |
| fill | output | 6 | Number of stored bytes |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted fill counter shows up at once on `fill`, `wr_ready` or `rd_valid`. It also shifts the trigger edge relative to the level in `thr_q`, so the bench sees the mismatch in the cycle after the bad update. A pointer error leaves the counter correct but puts the wrong byte on `rd_data`. That appears on the first pop that reaches the corrupted slot, at most 32 beats later. A lost sticky bit or a mis-masked threshold shows at `status` or `thr_q` one edge after the causing event. The bench therefore compares every output against a queue model on every clock, during both directed and random traffic.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int STS_TRIG = 7;
  localparam int STS_OVF  = 1;
  localparam int STS_UNF  = 0;

  typedef struct packed {
    logic trig;
    logic ovf;
    logic unf;
  } txq_flags_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/txq_ptrs.sv
module txq_ptrs #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          wr_ready,
  output logic          rd_valid,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          ovf_evt,
  output logic          unf_evt
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  assign wr_ready = (count != FULL_CNT);
  assign rd_valid = (count != '0);
  assign push     = push_req && wr_ready;
  assign pop      = pop_req && rd_valid;
  assign ovf_evt  = push_req && !wr_ready;
  assign unf_evt  = pop_req && !rd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 ||
              count == $past(count) - 1'b1));

  // R2
  fill_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !pop) |=> (count == FULL_CNT));
endmodule

// File: rtl/txq_status.sv
module txq_status
  import txq_pkg::*;
#(
  parameter int CW    = 6,
  parameter int LVL_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_we,
  input  logic [7:0]    thr_wdata,
  input  logic [CW-1:0] count,
  input  logic          ovf_evt,
  input  logic          unf_evt,
  input  logic          sts_clr,
  input  logic          irq_en,
  output logic [7:0]    thr_q,
  output logic [7:0]    status,
  output logic          irq
);
  localparam logic [7:0] LVL_MASK = 8'((1 << LVL_W) - 1);

  logic [7:0]  thr_r;
  txq_flags_t  fl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_r  <= '0;
      fl.ovf <= 1'b0;
      fl.unf <= 1'b0;
    end else begin
      if (thr_we) thr_r <= thr_wdata & LVL_MASK;
      if (ovf_evt)      fl.ovf <= 1'b1;
      else if (sts_clr) fl.ovf <= 1'b0;
      if (unf_evt)      fl.unf <= 1'b1;
      else if (sts_clr) fl.unf <= 1'b0;
    end
  end

  always_comb begin
    fl.trig = ({{(CW > 8 ? CW - 8 : 0){1'b0}}, count} <= {{(8 > CW ? 8 - CW : 0){1'b0}}, thr_r});
    status           = '0;
    status[STS_TRIG] = fl.trig;
    status[STS_OVF]  = fl.ovf;
    status[STS_UNF]  = fl.unf;
  end

  assign thr_q = thr_r;
  assign irq   = fl.trig && irq_en;

  // R4
  thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we |=> (thr_q == {3'b000, $past(thr_wdata[4:0])}));

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> status[STS_OVF]);

  // R8
  unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> status[STS_UNF]);

  // R10
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[STS_OVF] && !sts_clr) |=> status[STS_OVF]);
endmodule

// File: rtl/txq_lowwater_top.sv
module txq_lowwater_top #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  parameter int LVL_W = 5,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [W-1:0]  wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [W-1:0]  rd_data,
  input  logic          thr_we,
  input  logic [7:0]    thr_wdata,
  output logic [7:0]    thr_q,
  input  logic          irq_en,
  input  logic          sts_clr,
  output logic [7:0]    status,
  output logic [CW-1:0] fill,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);

  logic          push, pop, ovf_evt, unf_evt;
  logic [AW-1:0] wptr, rptr;
  logic [W-1:0]  head;

  txq_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push_req(wr_valid), .pop_req(rd_ready),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .push(push), .pop(pop),
    .wptr(wptr), .rptr(rptr), .count(fill),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  txq_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(push), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata(head)
  );

  txq_status #(.CW(CW), .LVL_W(LVL_W)) u_status (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .count(fill), .ovf_evt(ovf_evt), .unf_evt(unf_evt),
    .sts_clr(sts_clr), .irq_en(irq_en),
    .thr_q(thr_q), .status(status), .irq(irq)
  );

  assign rd_data = rd_valid ? head : '0;

  // R6
  pop_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (fill == $past(fill) - 1'b1));
endmodule

// File: tb/sim_txq_lowwater_top.sv
module sim_txq_lowwater_top;
  localparam int CLK_NS = 10;

  logic       clk = 0, rst_n = 0;
  logic       wr_valid = 0, rd_ready = 0, thr_we = 0, irq_en = 0, sts_clr = 0;
  logic [7:0] wr_data = 0, thr_wdata = 0;
  logic       wr_ready, rd_valid, irq;
  logic [7:0] rd_data, thr_q, status;
  logic [5:0] fill;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit cmp_en = 0;

  byte unsigned q[$];
  int  m_thr = 0;
  bit  m_ovf = 0, m_unf = 0;

  txq_lowwater_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .thr_q(thr_q), .irq_en(irq_en), .sts_clr(sts_clr), .status(status),
    .fill(fill), .irq(irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // reference model update on the clock edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete(); m_thr = 0; m_ovf = 0; m_unf = 0;
    end else begin
      automatic int  sz   = q.size();
      automatic bit  o_ev = wr_valid && sz == 32;
      automatic bit  u_ev = rd_ready && sz == 0;
      if (rd_ready && sz > 0) void'(q.pop_front());
      if (wr_valid && sz < 32) q.push_back(wr_data);
      if (o_ev) m_ovf = 1; else if (sts_clr) m_ovf = 0;
      if (u_ev) m_unf = 1; else if (sts_clr) m_unf = 0;
      if (thr_we) m_thr = thr_wdata & 8'h1f;
    end
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  // compare all outputs each cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      automatic int sz = q.size();
      automatic bit trg = (sz <= m_thr);
      chk("R1 wr_ready", wr_ready, sz < 32);
      chk("R2 fill", fill, sz);
      chk("R6 rd_valid", rd_valid, sz > 0);
      chk("R6/R8 rd_data", rd_data, sz > 0 ? q[0] : 0);
      chk("R4 thr_q", thr_q, m_thr);
      chk("R5 trigger", status[7], trg);
      chk("R7 overflow", status[1], m_ovf);
      chk("R8 underflow", status[0], m_unf);
      chk("R10 reserved", status[6:2], 0);
      chk("R9 irq", irq, trg && irq_en);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    wr_valid = 0; rd_ready = 0; thr_we = 0; sts_clr = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    cmp_en = 1;
    // R3: reset state
    chk("R3 status", status, 8'h80);
    chk("R3 fill", fill, 0);
    chk("R3 thr_q", thr_q, 0);
    // R4: reserved bits ignored
    thr_we = 1; thr_wdata = 8'hE5; tick(); idle();
    chk("R4 masked level", thr_q, 8'h05);
    irq_en = 1;
    // R1/R7: fill past full
    for (int i = 0; i < 34; i++) begin
      wr_valid = 1; wr_data = 8'(8'h30 + i); tick();
    end
    idle(); tick();
    chk("R7 overflow sticky", status[1], 1);
    chk("R1 full count", fill, 32);
    // R5: level 31 vs 32 stored
    thr_we = 1; thr_wdata = 8'hFF; tick(); idle();
    chk("R5 no trigger at 32>31", status[7], 0);
    // R2: push and pop together while full only pops
    wr_valid = 1; rd_ready = 1; wr_data = 8'hAA; tick(); idle();
    chk("R2 full push+pop", fill, 31);
    // R10: clear
    sts_clr = 1; tick(); idle();
    chk("R10 cleared", status[1:0], 0);
    // R6: drain and go one past empty
    for (int i = 0; i < 33; i++) begin
      rd_ready = 1; tick();
    end
    idle(); tick();
    chk("R8 underflow sticky", status[0], 1);
    chk("R8 empty data", rd_data, 0);
    // R10: clear with simultaneous underflow keeps bit
    sts_clr = 1; rd_ready = 1; tick(); idle();
    chk("R10 event wins", status[0], 1);
    // random traffic
    thr_we = 1; thr_wdata = 8'h08; tick(); idle();
    for (int i = 0; i < 3000; i++) begin
      wr_valid  = ($urandom_range(0, 99) < 55);
      rd_ready  = ($urandom_range(0, 99) < 45);
      wr_data   = 8'($urandom);
      sts_clr   = ($urandom_range(0, 99) < 5);
      thr_we    = ($urandom_range(0, 99) < 3);
      thr_wdata = 8'($urandom);
      irq_en    = ($urandom_range(0, 99) < 70);
      tick();
    end
    idle(); tick();
    report();
  end
endmodule